// File: doc/BRIEF.md
# Lane Interleave-to-Burst Corner Turner

A high-rate sampler hands over its stream as `LANES` parallel 2-bit lanes, and each lane carries every `LANES`-th sample. A correlator chain wants the opposite arrangement: one lane that holds a run of samples taken back to back in time. This block regroups the stream. Incoming samples are written into a three-bank sample store. Once a frame of `LANES*BURST` samples is complete, the frame is read out so that output lane `j` carries the `BURST` consecutive samples that begin at frame position `j*BURST`. All lanes emit their bursts together. The last sample of one burst and the first sample of the next therefore reach different lanes and are never paired, which is an accepted small loss.

Two static settings shape the output stream. The first is a decimation exponent. The block keeps one input sample in `2^e` and drops the rest, which serves lower effective sample rates. The second is a read offset. It delays the whole regrouped stream by a whole number of samples, which produces the displaced input that a cascaded higher-lag correlator needs. The offset may reach back into the previous frame, so the store holds three banks. One bank fills while one drains and the older frame stays readable. Both settings are held stable while the block is out of reset.

Top module: `lane_corner_turn`

## Requirements
- R1: During and after reset, `out_valid` and every bit of `out_first` are 0 until the first frame has been completed.
- R2: Input sample index `n` is the one on lane `n % LANES` (bits `[2k+1:2k]` of `in_lanes`, with k = n % LANES) of the `(n / LANES)`-th cycle with `in_valid` high since reset, counted from 0. With exponent 0 and offset 0, output burst `b`, lane `j`, position `p` carries sample `b*LANES*BURST + j*BURST + p`.
- R3: Each burst is `BURST` consecutive cycles of `out_valid`. The first one appears on the second rising edge after the edge that captures the input completing that frame.
- R4: With offset `O`, output burst `b`, lane `j`, position `p` carries kept-stream index `m = b*LANES*BURST + j*BURST + p - O`. When `m < 0` the lane carries 0.
- R5: Offset values above `LANES*BURST` act as `LANES*BURST`.
- R6: With exponent `e` and `D = 2^e`, only input samples with `n % D == 0` are kept. Kept-stream index `m` is input sample `m*D`, and a frame needs `BURST*D` valid input cycles.
- R7: Exponent values above `log2(LANES)` act as `log2(LANES)`.
- R8: Lane data in cycles with `in_valid` low is ignored and never appears at the output.
- R9: All bits of `out_first` are 1 on the first cycle of each burst and 0 on its other cycles, and they are 0 whenever `out_valid` is 0.
- R10: With exponent 0 and `in_valid` held high, successive bursts follow with no idle cycle, so `out_valid` rises only once.
- R11: Every completed frame yields exactly one burst, and a new frame never completes before the current burst reaches its last position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_decim_log2 | input | $clog2($clog2(LANES)+1) | Decimation exponent e, keep one sample in 2^e |
| cfg_offset | input | $clog2(LANES*BURST+1) | Read offset in kept samples |
| in_valid | input | 1 | Input lanes hold a new sample group |
| in_lanes | input | LANES*2 | Interleaved input samples, lane k at bits [2k+1:2k] |
| out_valid | output | 1 | Output lanes hold a burst sample |
| out_lanes | output | LANES*2 | Burst samples, lane j at bits [2j+1:2j] |
| out_first | output | LANES | Per-lane burst-start strobe |

## Verification
The main check drives random 2-bit data. A continuous input stream shows the base mapping and the back-to-back burst timing. A stream with random idle cycles and garbage data shows that only valid cycles are captured. Small, mid-range and whole-frame offsets separate three cases: reads inside the current frame, reads that cross into the previous bank, and the zero fill before the first frame. Several decimation exponents, along with out-of-range exponent and offset codes, tell apart the keep-one-in-D lane selection, the slot packing and the clamping.

// File: rtl/lct_pkg.sv
package lct_pkg;

   localparam int SMP_W = 2;
   localparam int NBANK = 3;

   typedef logic [SMP_W-1:0] smp_t;

   function automatic logic [1:0] bank_next(input logic [1:0] b);
      return (b == 2'd2) ? 2'd0 : b + 2'd1;
   endfunction

   function automatic logic [1:0] bank_prev(input logic [1:0] b);
      return (b == 2'd0) ? 2'd2 : b - 2'd1;
   endfunction

endpackage

// File: rtl/lct_wr_seq.sv
module lct_wr_seq
   import lct_pkg::*;
#(
   parameter int LANES = 32,
   parameter int BURST = 8
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic                                   in_valid,
   input  logic [$clog2($clog2(LANES)+1)-1:0]     dlog,
   output logic                                   wr_en,
   output logic [$clog2(NBANK*LANES*BURST)-1:0]   wr_base,
   output logic                                   frame_done,
   output logic [1:0]                             done_bank
);
   localparam int LOGL  = $clog2(LANES);
   localparam int PHW   = (LOGL > 0) ? LOGL : 1;
   localparam int PW    = $clog2(BURST);
   localparam int FRAME = LANES * BURST;
   localparam int AW    = $clog2(NBANK * FRAME);

   logic [PHW-1:0] phase;
   logic [PW-1:0]  word;
   logic [1:0]     bank;
   logic [PHW:0]   span;
   logic [PHW-1:0] phase_max;
   logic [AW-1:0]  slot_step;

   assign span      = {{PHW{1'b0}}, 1'b1} << dlog;
   assign phase_max = PHW'(span - 1'b1);
   assign slot_step = AW'(LANES >> dlog);
   assign wr_en     = in_valid;
   assign wr_base   = AW'(bank) * AW'(FRAME) + AW'(word) * AW'(LANES)
                    + AW'(phase) * slot_step;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase      <= '0;
         word       <= '0;
         bank       <= 2'd0;
         frame_done <= 1'b0;
         done_bank  <= 2'd0;
      end else begin
         frame_done <= 1'b0;
         if (in_valid) begin
            if (phase == phase_max) begin
               phase <= '0;
               if (word == PW'(BURST - 1)) begin
                  word       <= '0;
                  bank       <= bank_next(bank);
                  frame_done <= 1'b1;
                  done_bank  <= bank;
               end else begin
                  word <= word + 1'b1;
               end
            end else begin
               phase <= phase + 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/lct_bank_store.sv
module lct_bank_store
   import lct_pkg::*;
#(
   parameter int LANES = 32,
   parameter int BURST = 8
) (
   input  logic                                          clk,
   input  logic                                          rst_n,
   input  logic                                          wr_en,
   input  logic [$clog2(NBANK*LANES*BURST)-1:0]          wr_base,
   input  logic [$clog2($clog2(LANES)+1)-1:0]            dlog,
   input  logic [LANES*SMP_W-1:0]                        wr_data,
   input  logic [LANES*$clog2(NBANK*LANES*BURST)-1:0]    rd_addr,
   output logic [LANES*SMP_W-1:0]                        rd_data
);
   localparam int DEPTH = NBANK * LANES * BURST;
   localparam int AW    = $clog2(DEPTH);

   smp_t mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (wr_en) begin
         for (int k = 0; k < LANES; k++) begin
            if (((k >> dlog) << dlog) == k)
               mem[wr_base + AW'(k >> dlog)] <= wr_data[k*SMP_W +: SMP_W];
         end
      end
   end

   for (genvar j = 0; j < LANES; j++) begin : g_rd
      assign rd_data[j*SMP_W +: SMP_W] = mem[rd_addr[j*AW +: AW]];
   end

endmodule

// File: rtl/lct_rd_seq.sv
module lct_rd_seq
   import lct_pkg::*;
#(
   parameter int LANES = 32,
   parameter int BURST = 8
) (
   input  logic                                          clk,
   input  logic                                          rst_n,
   input  logic                                          frame_done,
   input  logic [1:0]                                    done_bank,
   input  logic [$clog2(LANES*BURST+1)-1:0]              ofs,
   output logic [LANES*$clog2(NBANK*LANES*BURST)-1:0]    rd_addr,
   output logic                                          rd_busy,
   output logic [$clog2(BURST)-1:0]                      rd_pos,
   output logic                                          rd_last
);
   localparam int FRAME = LANES * BURST;
   localparam int AW    = $clog2(NBANK * FRAME);
   localparam int PW    = $clog2(BURST);
   localparam int SW    = AW + 2;

   logic [1:0] cur_bank;
   logic [1:0] old_bank;

   assign old_bank = bank_prev(cur_bank);
   assign rd_last  = rd_busy && (rd_pos == PW'(BURST - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_busy  <= 1'b0;
         rd_pos   <= '0;
         cur_bank <= 2'd0;
      end else if (frame_done) begin
         rd_busy  <= 1'b1;
         rd_pos   <= '0;
         cur_bank <= done_bank;
      end else if (rd_busy) begin
         if (rd_last) rd_busy <= 1'b0;
         else         rd_pos  <= rd_pos + 1'b1;
      end
   end

   for (genvar j = 0; j < LANES; j++) begin : g_lane
      logic signed [SW-1:0] rel;
      logic [SW-1:0]        wrap;
      logic [1:0]           bsel;
      assign rel  = $signed(SW'(j * BURST)) + $signed(SW'(rd_pos)) - $signed(SW'(ofs));
      assign wrap = rel[SW-1] ? SW'(rel + SW'(FRAME)) : SW'(rel);
      assign bsel = rel[SW-1] ? old_bank : cur_bank;
      assign rd_addr[j*AW +: AW] = AW'(bsel) * AW'(FRAME) + AW'(wrap);
   end

endmodule

// File: rtl/lane_corner_turn.sv
module lane_corner_turn
   import lct_pkg::*;
#(
   parameter int LANES = 32,
   parameter int BURST = 8
) (
   input  logic                                      clk,
   input  logic                                      rst_n,
   input  logic [$clog2($clog2(LANES)+1)-1:0]        cfg_decim_log2,
   input  logic [$clog2(LANES*BURST+1)-1:0]          cfg_offset,
   input  logic                                      in_valid,
   input  logic [LANES*2-1:0]                        in_lanes,
   output logic                                      out_valid,
   output logic [LANES*2-1:0]                        out_lanes,
   output logic [LANES-1:0]                          out_first
);
   localparam int LOGL  = $clog2(LANES);
   localparam int DLW   = $clog2(LOGL + 1);
   localparam int FRAME = LANES * BURST;
   localparam int OFW   = $clog2(FRAME + 1);
   localparam int AW    = $clog2(NBANK * FRAME);
   localparam int PW    = $clog2(BURST);

   if (LANES < 2 || (1 << LOGL) != LANES) begin : g_bad_lanes
      $error("LANES must be a power of two and at least 2");
   end
   if (BURST < 2 || (1 << PW) != BURST) begin : g_bad_burst
      $error("BURST must be a power of two and at least 2");
   end
   if (SMP_W != 2) begin : g_bad_width
      $error("sample width must be 2 bits");
   end

   logic [DLW-1:0]          dlog_eff;
   logic [OFW-1:0]          ofs_eff;
   logic                    wr_en;
   logic [AW-1:0]           wr_base;
   logic                    wr_done;
   logic [1:0]              wr_done_bank;
   logic [LANES*AW-1:0]     rd_addr;
   logic [LANES*SMP_W-1:0]  rd_data;
   logic                    rd_busy;
   logic [PW-1:0]           rd_pos;
   logic                    rd_last;

   assign dlog_eff = (cfg_decim_log2 > DLW'(LOGL)) ? DLW'(LOGL) : cfg_decim_log2;
   assign ofs_eff  = (cfg_offset > OFW'(FRAME)) ? OFW'(FRAME) : cfg_offset;

   lct_wr_seq #(.LANES(LANES), .BURST(BURST)) wr_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (in_valid),
      .dlog       (dlog_eff),
      .wr_en      (wr_en),
      .wr_base    (wr_base),
      .frame_done (wr_done),
      .done_bank  (wr_done_bank)
   );

   lct_bank_store #(.LANES(LANES), .BURST(BURST)) store_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_base (wr_base),
      .dlog    (dlog_eff),
      .wr_data (in_lanes),
      .rd_addr (rd_addr),
      .rd_data (rd_data)
   );

   lct_rd_seq #(.LANES(LANES), .BURST(BURST)) rd_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .frame_done (wr_done),
      .done_bank  (wr_done_bank),
      .ofs        (ofs_eff),
      .rd_addr    (rd_addr),
      .rd_busy    (rd_busy),
      .rd_pos     (rd_pos),
      .rd_last    (rd_last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_lanes <= '0;
         out_first <= '0;
      end else begin
         out_valid <= rd_busy;
         out_lanes <= rd_data;
         out_first <= {LANES{rd_busy && (rd_pos == '0)}};
      end
   end

endmodule

// File: rtl/lct_chk.sv
module lct_chk #(
   parameter int LANES = 32,
   parameter int BURST = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             out_valid,
   input logic [LANES-1:0] out_first,
   input logic             frame_done,
   input logic             rd_busy,
   input logic             rd_last
);
   localparam int CW = $clog2(BURST) + 1;

   logic [CW-1:0] run_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          run_len <= '0;
      else if (out_valid)  run_len <= (out_first != '0) ? CW'(1) : run_len + 1'b1;
   end

   assert_strobe_needs_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_first != '0) |-> out_valid);

   assert_first_on_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !$past(out_valid)) |-> (out_first == '1));

   assert_burst_len_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(out_valid) |-> (run_len == CW'(BURST)));

   assert_burst_len_chain_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && $past(out_valid) && out_first != '0) |-> (run_len == CW'(BURST)));

   assert_no_overrun_R11: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |-> (!rd_busy || rd_last));

endmodule

bind lane_corner_turn lct_chk #(.LANES(LANES), .BURST(BURST)) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .out_valid  (out_valid),
   .out_first  (out_first),
   .frame_done (wr_done),
   .rd_busy    (rd_busy),
   .rd_last    (rd_last)
);

// File: tb/lane_corner_turn_tb.sv
module lane_corner_turn_tb_top;
   localparam int LANES = 32;
   localparam int BURST = 8;
   localparam int FRAME = LANES * BURST;
   localparam int DLW   = $clog2($clog2(LANES) + 1);
   localparam int OFW   = $clog2(FRAME + 1);
   localparam int NSMP  = 16384;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic [DLW-1:0]     cfg_decim_log2 = '0;
   logic [OFW-1:0]     cfg_offset = '0;
   logic               in_valid = 1'b0;
   logic [LANES*2-1:0] in_lanes = '0;
   logic               out_valid;
   logic [LANES*2-1:0] out_lanes;
   logic [LANES-1:0]   out_first;

   always #5 clk = ~clk;

   lane_corner_turn #(.LANES(LANES), .BURST(BURST)) dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_decim_log2(cfg_decim_log2), .cfg_offset(cfg_offset),
      .in_valid(in_valid), .in_lanes(in_lanes), .out_valid(out_valid),
      .out_lanes(out_lanes), .out_first(out_first));

   int tests = 0;
   int fails = 0;
   logic [1:0] smp [NSMP];
   int    cur_d, cur_ofs;
   string cur_tag;
   bit    mon_en = 1'b0;
   int    ncyc = 0, vcnt, done0, bcnt, pos, rises;
   bit    seen, prev_ov;

   task automatic chk(input string tag, input bit ok, input longint act, input longint exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic logic [1:0] expv(input int b, input int j, input int p);
      int m;
      m = b * FRAME + j * BURST + p - cur_ofs;
      if (m < 0) return 2'd0;
      return smp[m * cur_d];
   endfunction

   always @(negedge clk) begin
      ncyc++;
      if (mon_en) begin
         if (in_valid) begin
            vcnt++;
            if (vcnt == BURST * cur_d) done0 = ncyc;
         end
         if (out_valid) begin
            if (!prev_ov) rises++;
            if (!seen) begin
               seen = 1'b1;
               chk("R3 latency", ncyc == done0 + 3, ncyc - done0, 3);
            end
            for (int j = 0; j < LANES; j++)
               chk(cur_tag, out_lanes[j*2 +: 2] == expv(bcnt, j, pos),
                   out_lanes[j*2 +: 2], expv(bcnt, j, pos));
            chk("R9 strobe", out_first == ((pos == 0) ? {LANES{1'b1}} : {LANES{1'b0}}),
                out_first, (pos == 0) ? 1 : 0);
            pos++;
            if (pos == BURST) begin
               pos = 0;
               bcnt++;
            end
         end else begin
            chk("R9 idle strobe", out_first == '0, out_first, 0);
         end
         prev_ov = out_valid;
      end
   end

   task automatic run(input string tag, input int dcfg, input int ocfg,
                      input int nfr, input int gap);
      int nvalid;
      in_valid = 1'b0;
      rst_n = 1'b0;
      cfg_decim_log2 = DLW'(dcfg);
      cfg_offset = OFW'(ocfg);
      cur_d = 1 << ((dcfg > $clog2(LANES)) ? $clog2(LANES) : dcfg);
      cur_ofs = (ocfg > FRAME) ? FRAME : ocfg;
      cur_tag = tag;
      for (int n = 0; n < nfr * FRAME * cur_d; n++) smp[n] = 2'($urandom);
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1 in reset", out_valid == 1'b0 && out_first == '0, out_valid, 0);
      @(posedge clk);
      #1 rst_n = 1'b1;
      vcnt = 0; done0 = -100; bcnt = 0; pos = 0; rises = 0; seen = 1'b0; prev_ov = 1'b0;
      mon_en = 1'b1;
      nvalid = nfr * BURST * cur_d;
      for (int c = 0; c < nvalid; c++) begin
         while (gap > 0 && $urandom_range(99) < gap) begin
            in_valid = 1'b0;
            for (int k = 0; k < LANES; k++) in_lanes[k*2 +: 2] = 2'($urandom);
            @(posedge clk);
            #1;
         end
         in_valid = 1'b1;
         for (int k = 0; k < LANES; k++) in_lanes[k*2 +: 2] = smp[c * LANES + k];
         if (c == 0) chk("R1 before first frame", out_valid == 1'b0, out_valid, 0);
         @(posedge clk);
         #1;
      end
      in_valid = 1'b0;
      repeat (2 * BURST + 8) @(posedge clk);
      #1;
      mon_en = 1'b0;
      chk("R11 burst count", bcnt == nfr && pos == 0, bcnt, nfr);
      if (gap == 0 && cur_d == 1) chk("R10 back-to-back", rises == 1, rises, 1);
   endtask

   initial begin
      void'($urandom(20240611));
      run("R2 plain map", 0, 0, 4, 0);
      run("R8 gaps ignored", 0, 0, 3, 30);
      run("R4 offset small", 0, 13, 3, 0);
      run("R6 decim by 2", 1, 0, 3, 20);
      run("R4 offset full frame", 2, FRAME, 3, 0);
      run("R5 offset clamp", 0, 511, 3, 0);
      run("R7 decim clamp", 7, 0, 2, 0);
      run("R6 decim by 8 offset", 3, 1, 2, 15);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      tests++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule